// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous system port and an external asynchronous 128K x 16 static RAM. A request carries a word address, a write flag, write data, two byte-lane enables and an optional page-burst length. The block converts each request into active-low chip-select, output-enable, write-strobe and byte-strobe waveforms. It controls the enable of its own data drivers. It counts clock cycles so that every access meets the memory's minimum timings, which are given as nanosecond parameters next to the clock period.

The request side is a valid/ready interface. A request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must hold all request fields steady. The read response is a one-cycle `rsp_valid` pulse with no back-pressure, so the consumer must take every pulse. A write completes with a one-cycle `wr_done` pulse.

A page burst read keeps address bits 16..4 (the page) fixed and steps bits 3..0 (the word). It wraps modulo 16 inside the page and returns one response per word, in order.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` is 0, and `rsp_valid` and `wr_done` are 0.
- R2: Whenever `req_ready` is high, the memory is in standby: `sram_ce_n` is 1 and `sram_dq_oe` is 0.
- R3: A single read holds `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 with a steady address for the read window. It samples `sram_dq_in` in the window's last cycle and presents that word on `rsp_rdata` with a one-cycle `rsp_valid` pulse.
- R4: A write drives `sram_we_n` low for exactly the pulse count. One setup cycle with `sram_we_n` high comes before the pulse, and `sram_ce_n` stays low for at least the write-cycle count. The write ends with a one-cycle `wr_done` pulse.
- R5: `req_be[0]` selects data bits 7..0 through `sram_lb_n`=0, and `req_be[1]` selects bits 15..8 through `sram_ub_n`=0. A write with one lane enabled leaves the other byte of the word unchanged.
- R6: Throughout a write, `sram_oe_n` is 1 and `sram_dq_oe` is 1.
- R7: `sram_dq_oe` and a low `sram_oe_n` are never present together. After a read ends, `sram_oe_n` stays high for at least the high-impedance count plus one cycle before `sram_dq_oe` rises.
- R8: A read with `req_burst`=1 and `req_len`=N returns N+1 words. Their addresses share bits 16..4 with the start address, and bits 3..0 increase by one modulo 16 from the start word. Each word gets its own read window and its own `rsp_valid` pulse, in order.
- R9: Each cycle count equals the nanosecond minimum divided by `CLK_NS`, rounded up, with a floor of 1. The read window also covers the output-enable access time, and the pulse also covers the data setup time. With `CLK_NS`=20 this gives a 4-cycle read window, a 2-cycle write pulse and a 4-cycle write cycle.
- R10: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` falls in the cycle after acceptance and stays low until the access and any turnaround are complete.
- R11: On a write, `req_burst` and `req_len` have no effect: exactly one word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address (bits 16..4 page, 3..0 word) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 1 upper, bit 0 lower |
| req_burst | input | 1 | Page burst read request |
| req_len | input | 4 | Extra words in a burst (N+1 words in total) |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 16 | Read data |
| wr_done | output | 1 | One-cycle write completion pulse |
| sram_addr | output | 17 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_ub_n | output | 1 | Upper byte strobe, active low |
| sram_lb_n | output | 1 | Lower byte strobe, active low |
| sram_dq_out | output | 16 | Data driven to memory |
| sram_dq_oe | output | 1 | Enable for the data drivers |
| sram_dq_in | input | 16 | Data from memory |

## Verification
The bench builds the controller with `CLK_NS`=20 and keeps the default nanosecond minimums. The windows are then short: 4 read cycles, 2 pulse cycles, 4 write cycles and 1 turnaround cycle. Its memory model returns a poison word until the address has been steady for the full read window, so a capture taken even one cycle early shows up as a data mismatch. At these sizes a 16-word page sweep and a burst that wraps from word 14 to word 1 each fit in a few dozen cycles. The exact pulse widths and window lengths are also checked against values the bench derives from the nanosecond figures.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WSET,
    ST_WPUL,
    ST_WREC
  } acc_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/asram_addr.sv
module asram_addr #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WORD_W-1:0] extra_words,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [WORD_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      left <= '0;
    end else if (load) begin
      addr <= start_addr;
      left <= extra_words;
    end else if (step) begin
      // page bits stay, word bits wrap inside the page
      addr[WORD_W-1:0] <= addr[WORD_W-1:0] + 1'b1;
      left             <= left - 1'b1;
    end
  end

  assign last = (left == '0);
endmodule

// File: rtl/asram_dq.sv
module asram_dq #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive_nxt,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (load_wr) dq_out <= wdata;
      dq_oe <= drive_nxt;
      if (capture) rdata <= dq_in;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned WORD_W   = 4,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_RC_NS  = 70,
  parameter int unsigned T_OE_NS  = 35,
  parameter int unsigned T_WC_NS  = 70,
  parameter int unsigned T_WP_NS  = 40,
  parameter int unsigned T_DW_NS  = 20,
  parameter int unsigned T_HZ_NS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  input  logic              req_burst,
  input  logic [WORD_W-1:0] req_len,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wr_done,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int unsigned RC_CYC  = ns2cyc(T_RC_NS, CLK_NS);
  localparam int unsigned OE_CYC  = ns2cyc(T_OE_NS, CLK_NS);
  localparam int unsigned RD_CYC  = (RC_CYC > OE_CYC) ? RC_CYC : OE_CYC;
  localparam int unsigned WPR_CYC = ns2cyc(T_WP_NS, CLK_NS);
  localparam int unsigned DW_CYC  = ns2cyc(T_DW_NS, CLK_NS);
  localparam int unsigned WP_CYC  = (WPR_CYC > DW_CYC) ? WPR_CYC : DW_CYC;
  localparam int unsigned WC_CYC  = ns2cyc(T_WC_NS, CLK_NS);
  localparam int unsigned REC_CYC = (WC_CYC > WP_CYC + 1) ? WC_CYC - WP_CYC - 1 : 1;
  localparam int unsigned HZ_CYC  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned MAX_A   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int unsigned MAX_B   = (REC_CYC > HZ_CYC) ? REC_CYC : HZ_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1) + 1;

  acc_state_e        state, nxt;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              a_load, a_step, a_last;
  logic              acc_go, cap, wr_end, drive_nxt;
  logic [WORD_W-1:0] extra;

  assign req_ready = (state == ST_IDLE);
  assign extra     = (req_burst && !req_write) ? req_len : '0;
  assign drive_nxt = (nxt == ST_WSET) || (nxt == ST_WPUL) || (nxt == ST_WREC);

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    a_load   = 1'b0;
    a_step   = 1'b0;
    acc_go   = 1'b0;
    cap      = 1'b0;
    wr_end   = 1'b0;
    case (state)
      ST_IDLE: if (req_valid) begin
        acc_go   = 1'b1;
        a_load   = 1'b1;
        tmr_load = 1'b1;
        if (req_write) begin
          nxt     = ST_WSET;
          tmr_val = '0;
        end else begin
          nxt     = ST_READ;
          tmr_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_READ: if (tmr_done) begin
        cap      = 1'b1;
        tmr_load = 1'b1;
        if (a_last) begin
          nxt     = ST_TURN;
          tmr_val = CNT_W'(HZ_CYC - 1);
        end else begin
          a_step  = 1'b1;
          tmr_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_TURN: if (tmr_done) nxt = ST_IDLE;
      ST_WSET: if (tmr_done) begin
        nxt      = ST_WPUL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_CYC - 1);
      end
      ST_WPUL: if (tmr_done) begin
        nxt      = ST_WREC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(REC_CYC - 1);
      end
      ST_WREC: if (tmr_done) begin
        nxt    = ST_IDLE;
        wr_end = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sram_ce_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_ub_n <= 1'b1;
      sram_lb_n <= 1'b1;
      rsp_valid <= 1'b0;
      wr_done   <= 1'b0;
    end else begin
      state     <= nxt;
      sram_ce_n <= (nxt == ST_IDLE) || (nxt == ST_TURN);
      sram_oe_n <= (nxt != ST_READ);
      sram_we_n <= (nxt != ST_WPUL);
      if (acc_go) begin
        sram_ub_n <= ~req_be[1];
        sram_lb_n <= ~req_be[0];
      end else if ((nxt == ST_IDLE) || (nxt == ST_TURN)) begin
        sram_ub_n <= 1'b1;
        sram_lb_n <= 1'b1;
      end
      rsp_valid <= cap;
      wr_done   <= wr_end;
    end
  end

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
  );

  asram_addr #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(a_load), .start_addr(req_addr),
    .extra_words(extra), .step(a_step), .addr(sram_addr), .last(a_last)
  );

  asram_dq #(.DATA_W(DATA_W)) u_dq (
    .clk(clk), .rst_n(rst_n), .load_wr(acc_go && req_write), .wdata(req_wdata),
    .drive_nxt(drive_nxt), .capture(cap), .dq_in(sram_dq_in),
    .dq_out(sram_dq_out), .dq_oe(sram_dq_oe), .rdata(rsp_rdata)
  );

  // cycles the write strobe has been low, kept for the cycle it rises
  logic [CNT_W-1:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          we_low_cnt <= '0;
    else if (!sram_we_n) we_low_cnt <= we_low_cnt + 1'b1;
    else                 we_low_cnt <= '0;
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && !sram_dq_oe)); // R2
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R7
  AST_WRITE_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && sram_dq_oe && !sram_ce_n)); // R6
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n && $past(!sram_oe_n)) |-> (sram_addr[ADDR_W-1:WORD_W] == $past(sram_addr[ADDR_W-1:WORD_W]))); // R8
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_cnt == CNT_W'(WP_CYC))); // R4
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> $past(sram_oe_n)); // R7
endmodule

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
  localparam int CLK_NS = 20;
  localparam int RD_EXP = (70 + CLK_NS - 1) / CLK_NS;
  localparam int WP_EXP = (40 + CLK_NS - 1) / CLK_NS;
  localparam int WC_EXP = (70 + CLK_NS - 1) / CLK_NS;
  localparam int HZ_EXP = (20 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic [3:0]  req_len = '0;
  logic        rsp_valid, wr_done;
  logic [15:0] rsp_rdata;
  logic [16:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe;
  logic [15:0] sram_dq_out;
  logic [15:0] sram_dq_in = 16'hDEAD;

  always #10 clk = ~clk;

  asram_ctrl #(.CLK_NS(CLK_NS)) i_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_burst(req_burst), .req_len(req_len), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .wr_done(wr_done), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int checks = 0, fails = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and shadow copy
  logic [15:0] mem    [int];
  logic [15:0] shadow [int];
  logic [15:0] exp_q  [$];
  int writes_exp = 0, writes_seen = 0;

  function automatic logic [15:0] mrd(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  int          st = 0, we_lo = 0, ce_lo = 0, oe_hi = 100;
  bit          prev_rd = 0, prev_we_n = 1, prev_ce_n = 1, prev_dq_oe = 0, after_read = 0, was_wr = 0;
  logic [16:0] prev_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sram_dq_oe && !sram_oe_n) chk(0, "R7", 1, 0);
      if (sram_dq_oe && !prev_dq_oe && after_read) begin
        chk(oe_hi >= HZ_EXP + 1, "R7", oe_hi, HZ_EXP + 1);
        after_read = 0;
      end
      if (!sram_oe_n) begin oe_hi = 0; after_read = 1; end else oe_hi++;
      if (!sram_we_n) begin
        we_lo++;
        was_wr = 1;
        if (!sram_dq_oe || !sram_oe_n) chk(0, "R6", sram_oe_n, 1);
      end
      if (sram_we_n && !prev_we_n) begin
        chk(we_lo == WP_EXP, "R4", we_lo, WP_EXP);
        chk(sram_dq_oe && sram_oe_n, "R6", {sram_dq_oe, sram_oe_n}, 2'b11);
        if (!sram_lb_n) mem[int'(sram_addr)] = {mrd(int'(sram_addr))[15:8], sram_dq_out[7:0]};
        if (!sram_ub_n) mem[int'(sram_addr)] = {sram_dq_out[15:8], mrd(int'(sram_addr))[7:0]};
        we_lo = 0;
      end
      if (!sram_ce_n) ce_lo++;
      if (sram_ce_n && !prev_ce_n) begin
        if (was_wr) chk(ce_lo >= WC_EXP, "R4", ce_lo, WC_EXP);
        ce_lo = 0; was_wr = 0;
      end
      if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
        if (prev_rd && sram_addr == prev_addr) st++;
        else begin
          if (prev_rd) begin
            chk(sram_addr[16:4] == prev_addr[16:4], "R8", sram_addr[16:4], prev_addr[16:4]);
            chk(st == RD_EXP, "R9", st, RD_EXP);
          end
          st = 1;
        end
        prev_rd = 1;
      end else begin
        if (prev_rd) chk(st == RD_EXP, "R9", st, RD_EXP);
        st = 0; prev_rd = 0;
      end
      sram_dq_in <= (st >= RD_EXP) ? mrd(int'(sram_addr)) : 16'hDEAD;
      prev_addr  = sram_addr;
      prev_we_n  = sram_we_n;
      prev_ce_n  = sram_ce_n;
      prev_dq_oe = sram_dq_oe;
    end
  end

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R3", rsp_rdata, 0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        chk(rsp_rdata == e, "R3", rsp_rdata, e);
      end
    end
    if (rst_n && wr_done) writes_seen++;
  end

  task automatic send(input bit wr, input logic [16:0] a, input logic [15:0] d,
                      input logic [1:0] be, input bit burst, input logic [3:0] len);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    req_be = be; req_burst = burst; req_len = len;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10", req_ready, 0);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be,
                          input bit burst = 0, input logic [3:0] len = 0);
    logic [15:0] old;
    old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (be[0]) old[7:0]  = d[7:0];
    if (be[1]) old[15:8] = d[15:8];
    shadow[int'(a)] = old;
    writes_exp++;
    send(1, a, d, be, burst, len);
  endtask

  task automatic do_read(input logic [16:0] a, input bit burst = 0, input logic [3:0] len = 0);
    int n;
    n = burst ? int'(len) + 1 : 1;
    for (int i = 0; i < n; i++) begin
      automatic logic [16:0] w = {a[16:4], 4'(a[3:0] + 4'(i))};
      exp_q.push_back(shadow.exists(int'(w)) ? shadow[int'(w)] : 16'h0000);
    end
    send(0, a, 16'h0, 2'b11, burst, len);
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    do begin @(negedge clk); t++; end while ((!req_ready || exp_q.size() != 0) && t < 1000);
    chk(req_ready && sram_ce_n && !sram_dq_oe, "R2", {req_ready, sram_ce_n, sram_dq_oe}, 3'b110);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done_flag) begin
      done_flag = 1;
      chk(0, "watchdog", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(req_ready == 1, "R1", req_ready, 1);
    chk({sram_ce_n, sram_oe_n, sram_we_n} == 3'b111, "R1", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
    chk(!sram_dq_oe && !rsp_valid && !wr_done, "R1", {sram_dq_oe, rsp_valid, wr_done}, 0);
    rst_n = 1;
    @(negedge clk);

    // R4 R5 full and partial writes, R3 reads
    do_write(17'h00010, 16'hA5C3, 2'b11);
    do_write(17'h1FFFF, 16'h1234, 2'b11);
    do_write(17'h00010, 16'hFF77, 2'b01);   // R5 lower only
    do_write(17'h1FFFF, 16'h9900, 2'b10);   // R5 upper only
    wait_idle();
    do_read(17'h00010);                     // expect A577
    do_read(17'h1FFFF);                     // expect 9934
    wait_idle();
    chk(mrd(32'h10) == 16'hA577, "R5", mrd(32'h10), 16'hA577);
    chk(mrd(32'h1FFFF) == 16'h9934, "R5", mrd(32'h1FFFF), 16'h9934);

    // R7 write straight after a read
    do_read(17'h00010);
    do_write(17'h00011, 16'h0BAD, 2'b11);
    do_read(17'h00011);
    wait_idle();

    // R8 fill a page and sweep it, then a wrapping burst
    for (int i = 0; i < 16; i++) do_write({13'h0ABC, 4'(i)}, 16'(16'h3000 + i * 7), 2'b11);
    do_read({13'h0ABC, 4'h0}, 1, 4'hF);
    wait_idle();
    do_read({13'h0ABC, 4'hE}, 1, 4'h3);     // words 14,15,0,1
    wait_idle();
    // R3: single read ignores req_len when burst is low
    do_read({13'h0ABC, 4'h5}, 0, 4'h7);
    wait_idle();

    // R11 a write with burst fields writes one word only
    do_write({13'h0111, 4'h2}, 16'hCAFE, 2'b11, 1, 4'h4);
    wait_idle();
    chk(mrd({15'h0, 13'h0111, 4'h3}) == 16'h0000, "R11", mrd({15'h0, 13'h0111, 4'h3}), 0);
    do_read({13'h0111, 4'h2}, 1, 4'h2);
    wait_idle();

    chk(writes_seen == writes_exp, "R4", writes_seen, writes_exp);
    chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule